// File: doc/BRIEF.md
# Paired-Block Interrupt Aggregator

This block gathers the interrupt sources of four dual-channel serial blocks and folds them onto two interrupt lines. Each serial block owns an 8-bit status register, set and cleared by single-cycle pulses from the channel logic: transmitter ready, receiver ready and break for each of its two channels. Each block also owns an 8-bit mask register. A line is raised when either block of its pair holds a status bit whose mask bit is also set. Blocks 0 and 1 drive line 0. Blocks 2 and 3 drive line 1.

A host reaches the block over a byte bus. A 2-bit space selector picks one of four address spaces: register, identification, acknowledge and memory. In the register space, status and mask share one offset. A read there returns the status and a write there loads the mask. An interrupt-acknowledge cycle is a read in the acknowledge space, and it returns a vector byte that the host programmed earlier. One vector serves both lines.

Top module: `intr_pair_agg`

## Requirements
- R1: After reset the status registers, mask registers, vector byte, read data and both interrupt lines are zero.
- R2: Status layout per block: bit 0 TX-ready, bit 1 RX-ready, bit 2 break for the block's even channel, and bits 4, 5 and 6 the same sources for its odd channel. Bits 3 and 7 always read zero. Channel n belongs to block n/2.
- R3: A set pulse sets its status bit and a clear pulse clears it, one clock later. When both arrive in the same cycle, the clear wins.
- R4: A block's break-reset pulse clears bits 2 and 6 of that block only. It wins over a break set pulse arriving in the same cycle.
- R5: In the register space (selector 0), the status/mask register of block b sits at address b*32+10, so the block index is taken from address bits 6:5 and the offset from bits 4:0. A read there returns the status and a write there loads the mask. Writes at any other register-space offset change no mask.
- R6: Line l is high when (status AND mask) is nonzero for block 2l or block 2l+1. The line is registered, so it follows a status or mask change by one further clock.
- R7: A read in the acknowledge space (selector 2) at address 0 (line 0) or address 2 (line 1) returns the vector byte. Reads at any other acknowledge address return zero.
- R8: The vector byte is loaded by a write at address 1 of the identification space (selector 1) or at address 1 of the memory space (selector 3). Writes at other addresses in those spaces leave the vector unchanged.
- R9: Read data is registered. It appears on the clock edge that samples the read and holds until the next read. Reads in the identification and memory spaces return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_set_i | input | 8 | Per-channel TX-ready set pulse |
| tx_clr_i | input | 8 | Per-channel TX-ready clear pulse |
| rx_set_i | input | 8 | Per-channel RX-ready set pulse |
| rx_clr_i | input | 8 | Per-channel RX-ready clear pulse |
| brk_set_i | input | 8 | Per-channel break set pulse |
| brk_blk_clr_i | input | 4 | Per-block break-reset pulse |
| bus_space_i | input | 2 | Address space select: 0 register, 1 identification, 2 acknowledge, 3 memory |
| bus_addr_i | input | 8 | Byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 2 | Interrupt lines, active high |

## Verification
The bench builds the block with its default of four blocks. This yields two lines and eight channels, so every pairing is reachable. A source in one block can be checked against the line of its own pair, and against the absence of any effect on the other line. It also exercises both channel slots inside a block and every acknowledge address.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam int STAT_W = 8;
  localparam int SLOT_SPAN = 4;
  localparam int POS_TX = 0;
  localparam int POS_RX = 1;
  localparam int POS_BRK = 2;
  localparam int POS_SPARE = 3;

  typedef enum logic [1:0] {
    SP_REG = 2'd0,
    SP_ID  = 2'd1,
    SP_ACK = 2'd2,
    SP_MEM = 2'd3
  } bus_space_e;
endpackage

// File: rtl/intr_blk_stat.sv
module intr_blk_stat
  import intr_agg_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOTS-1:0]  tx_set,
  input  logic [SLOTS-1:0]  tx_clr,
  input  logic [SLOTS-1:0]  rx_set,
  input  logic [SLOTS-1:0]  rx_clr,
  input  logic [SLOTS-1:0]  brk_set,
  input  logic              brk_clr,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] mask_q
);
  logic [STAT_W-1:0] stat_d;
  logic [STAT_W-1:0] mask_d;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int BASE = s * SLOT_SPAN;
    // clear has priority over set in the same cycle
    assign stat_d[BASE+POS_TX]    = tx_clr[s] ? 1'b0 : (tx_set[s] ? 1'b1 : stat_q[BASE+POS_TX]);
    assign stat_d[BASE+POS_RX]    = rx_clr[s] ? 1'b0 : (rx_set[s] ? 1'b1 : stat_q[BASE+POS_RX]);
    assign stat_d[BASE+POS_BRK]   = brk_clr   ? 1'b0 : (brk_set[s] ? 1'b1 : stat_q[BASE+POS_BRK]);
    assign stat_d[BASE+POS_SPARE] = 1'b0;
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/intr_line_merge.sv
module intr_line_merge
  import intr_agg_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  localparam int NUM_LINES = NUM_BLOCKS / 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_BLOCKS-1:0][STAT_W-1:0]  stat_all,
  input  logic [NUM_BLOCKS-1:0][STAT_W-1:0]  mask_all,
  output logic [NUM_LINES-1:0]               irq_q
);
  logic [NUM_BLOCKS-1:0] blk_req;
  logic [NUM_LINES-1:0]  irq_d;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_req
    assign blk_req[b] = |(stat_all[b] & mask_all[b]);
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign irq_d[l] = blk_req[2*l] | blk_req[2*l+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/intr_bus_if.sv
module intr_bus_if
  import intr_agg_pkg::*;
#(
  parameter int          NUM_BLOCKS = 4,
  parameter int          AW = 8,
  parameter logic [4:0]  STAT_OFS = 5'h0A,
  localparam int NUM_LINES = NUM_BLOCKS / 2,
  localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [1:0]                         bus_space,
  input  logic [AW-1:0]                      bus_addr,
  input  logic                               bus_wr,
  input  logic                               bus_rd,
  input  logic [STAT_W-1:0]                  bus_wdata,
  input  logic [NUM_BLOCKS-1:0][STAT_W-1:0]  stat_all,
  output logic [NUM_BLOCKS-1:0]              mask_we,
  output logic [STAT_W-1:0]                  vec_q,
  output logic [STAT_W-1:0]                  rdata_q
);
  logic              reg_hit;
  logic [BW-1:0]     blk_idx;
  logic              vec_we;
  logic              ack_hit;
  logic [STAT_W-1:0] rd_sel;
  logic [STAT_W-1:0] rdata_d;
  logic [STAT_W-1:0] vec_d;

  always_comb begin
    blk_idx = bus_addr[5 +: BW];
    reg_hit = (bus_space == SP_REG) && (bus_addr[4:0] == STAT_OFS);
    ack_hit = !bus_addr[0] && (int'(bus_addr[AW-1:1]) < NUM_LINES);
    vec_we  = bus_wr && ((bus_space == SP_ID) || (bus_space == SP_MEM)) &&
              (bus_addr == AW'(1));
    mask_we = '0;
    if (bus_wr && reg_hit) mask_we[blk_idx] = 1'b1;
  end

  always_comb begin
    rd_sel = '0;
    case (bus_space)
      SP_REG:  if (reg_hit) rd_sel = stat_all[blk_idx];
      SP_ACK:  if (ack_hit) rd_sel = vec_q;
      default: rd_sel = '0;
    endcase
    rdata_d = bus_rd ? rd_sel : rdata_q;
    vec_d   = vec_we ? bus_wdata : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      rdata_q <= '0;
    end else begin
      vec_q   <= vec_d;
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/intr_pair_agg.sv
module intr_pair_agg
  import intr_agg_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int AW = 8,
  localparam int SLOTS = 2,
  localparam int NUM_CH = NUM_BLOCKS * SLOTS,
  localparam int NUM_LINES = NUM_BLOCKS / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     tx_set_i,
  input  logic [NUM_CH-1:0]     tx_clr_i,
  input  logic [NUM_CH-1:0]     rx_set_i,
  input  logic [NUM_CH-1:0]     rx_clr_i,
  input  logic [NUM_CH-1:0]     brk_set_i,
  input  logic [NUM_BLOCKS-1:0] brk_blk_clr_i,
  input  logic [1:0]            bus_space_i,
  input  logic [AW-1:0]         bus_addr_i,
  input  logic                  bus_wr_i,
  input  logic                  bus_rd_i,
  input  logic [STAT_W-1:0]     bus_wdata_i,
  output logic [STAT_W-1:0]     bus_rdata_o,
  output logic [NUM_LINES-1:0]  irq_o
);
  logic [NUM_BLOCKS-1:0][STAT_W-1:0] stat_all;
  logic [NUM_BLOCKS-1:0][STAT_W-1:0] mask_all;
  logic [NUM_BLOCKS-1:0]             mask_we;
  logic [STAT_W-1:0]                 vec_q;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    intr_blk_stat #(.SLOTS(SLOTS)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_set     (tx_set_i[b*SLOTS +: SLOTS]),
      .tx_clr     (tx_clr_i[b*SLOTS +: SLOTS]),
      .rx_set     (rx_set_i[b*SLOTS +: SLOTS]),
      .rx_clr     (rx_clr_i[b*SLOTS +: SLOTS]),
      .brk_set    (brk_set_i[b*SLOTS +: SLOTS]),
      .brk_clr    (brk_blk_clr_i[b]),
      .mask_we    (mask_we[b]),
      .mask_wdata (bus_wdata_i),
      .stat_q     (stat_all[b]),
      .mask_q     (mask_all[b])
    );
  end

  intr_line_merge #(.NUM_BLOCKS(NUM_BLOCKS)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_all (stat_all),
    .mask_all (mask_all),
    .irq_q    (irq_o)
  );

  intr_bus_if #(.NUM_BLOCKS(NUM_BLOCKS), .AW(AW)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_space (bus_space_i),
    .bus_addr  (bus_addr_i),
    .bus_wr    (bus_wr_i),
    .bus_rd    (bus_rd_i),
    .bus_wdata (bus_wdata_i),
    .stat_all  (stat_all),
    .mask_we   (mask_we),
    .vec_q     (vec_q),
    .rdata_q   (bus_rdata_o)
  );
endmodule

// File: rtl/intr_pair_agg_chk.sv
module intr_pair_agg_chk
  import intr_agg_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int AW = 8,
  localparam int NUM_CH = NUM_BLOCKS * 2,
  localparam int NUM_LINES = NUM_BLOCKS / 2
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_CH-1:0]                 tx_set_i,
  input logic [NUM_CH-1:0]                 tx_clr_i,
  input logic [NUM_BLOCKS-1:0]             brk_blk_clr_i,
  input logic [1:0]                        bus_space_i,
  input logic [AW-1:0]                     bus_addr_i,
  input logic                              bus_rd_i,
  input logic [STAT_W-1:0]                 bus_rdata_o,
  input logic [NUM_LINES-1:0]              irq_o,
  input logic [NUM_BLOCKS-1:0][STAT_W-1:0] stat_all,
  input logic [NUM_BLOCKS-1:0][STAT_W-1:0] mask_all,
  input logic [STAT_W-1:0]                 vec_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assert_tx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_set_i[c] && !tx_clr_i[c]) |=> stat_all[c/2][(c%2)*4 + POS_TX]);
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_b
    assert_brk_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      brk_blk_clr_i[b] |=> (!stat_all[b][2] && !stat_all[b][6]));
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_l
    assert_line_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_all[2*l] == '0 && mask_all[2*l+1] == '0) |=> !irq_o[l]);
    assert_line_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_all[2*l+1] & mask_all[2*l+1])) |=> irq_o[l]);
  end

  assert_ack_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_space_i == SP_ACK && bus_addr_i == '0) |=> (bus_rdata_o == $past(vec_q)));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

bind intr_pair_agg intr_pair_agg_chk #(.NUM_BLOCKS(NUM_BLOCKS), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_set_i      (tx_set_i),
  .tx_clr_i      (tx_clr_i),
  .brk_blk_clr_i (brk_blk_clr_i),
  .bus_space_i   (bus_space_i),
  .bus_addr_i    (bus_addr_i),
  .bus_rd_i      (bus_rd_i),
  .bus_rdata_o   (bus_rdata_o),
  .irq_o         (irq_o),
  .stat_all      (stat_all),
  .mask_all      (mask_all),
  .vec_q         (vec_q)
);

// File: tb/tb_intr_pair_agg.sv
module tb_intr_pair_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NCH = 8;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] tx_set, tx_clr, rx_set, rx_clr, brk_set;
  logic [NB-1:0]  brk_blk_clr;
  logic [1:0]     space;
  logic [7:0]     addr;
  logic           wr, rd;
  logic [7:0]     wdata;
  logic [7:0]     rdata;
  logic [1:0]     irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  intr_pair_agg #(.NUM_BLOCKS(NB)) dut (
    .clk(clk), .rst_n(rst_n),
    .tx_set_i(tx_set), .tx_clr_i(tx_clr), .rx_set_i(rx_set), .rx_clr_i(rx_clr),
    .brk_set_i(brk_set), .brk_blk_clr_i(brk_blk_clr),
    .bus_space_i(space), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    tx_set = '0; tx_clr = '0; rx_set = '0; rx_clr = '0; brk_set = '0;
    brk_blk_clr = '0; wr = 0; rd = 0; space = 2'd0; addr = '0; wdata = '0;
  endtask

  // release pulses at the next falling edge
  task automatic settle();
    @(negedge clk);
    idle_in();
  endtask

  task automatic bus_write(input logic [1:0] sp, input logic [7:0] a, input logic [7:0] d);
    space = sp; addr = a; wdata = d; wr = 1;
    settle();
  endtask

  task automatic bus_read(input logic [1:0] sp, input logic [7:0] a, output logic [7:0] d);
    space = sp; addr = a; rd = 1;
    @(negedge clk);
    d = rdata;
    idle_in();
  endtask

  function automatic logic [7:0] stat_addr(input int b);
    return 8'(b * 32 + 10);
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rdata", int'(rdata), 0);
    check("R1 irq", int'(irq), 0);
    for (int b = 0; b < NB; b++) begin
      bus_read(2'd0, stat_addr(b), d);
      check("R1 status", int'(d), 0);
    end
    bus_read(2'd2, 8'd0, d);
    check("R1 vector", int'(d), 0);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    tx_set[5] = 1; rx_set[0] = 1; brk_set[3] = 1;
    settle();
    bus_read(2'd0, stat_addr(0), d); check("R2 blk0 even rx", int'(d), 8'h02);
    bus_read(2'd0, stat_addr(1), d); check("R2 blk1 odd brk", int'(d), 8'h40);
    bus_read(2'd0, stat_addr(2), d); check("R2 blk2 odd tx", int'(d), 8'h10);
    bus_read(2'd0, stat_addr(3), d); check("R2 blk3 empty", int'(d), 8'h00);
  endtask

  task automatic t_setclr();
    logic [7:0] d;
    tx_set[0] = 1; tx_clr[0] = 1;
    settle();
    bus_read(2'd0, stat_addr(0), d); check("R3 clear wins", int'(d), 8'h02);
    rx_clr[0] = 1; tx_clr[5] = 1;
    settle();
    bus_read(2'd0, stat_addr(0), d); check("R3 rx clear", int'(d), 8'h00);
    bus_read(2'd0, stat_addr(2), d); check("R3 tx clear", int'(d), 8'h00);
  endtask

  task automatic t_break();
    logic [7:0] d;
    brk_set[2] = 1; tx_set[2] = 1;
    settle();
    bus_read(2'd0, stat_addr(1), d); check("R4 both breaks", int'(d), 8'h45);
    brk_blk_clr[1] = 1; brk_set[2] = 1;
    settle();
    bus_read(2'd0, stat_addr(1), d); check("R4 reset keeps tx", int'(d), 8'h01);
    tx_clr[2] = 1;
    settle();
  endtask

  task automatic t_mask_irq();
    rx_set[6] = 1;
    settle();
    @(negedge clk);
    check("R6 unmasked stays low", int'(irq), 0);
    bus_write(2'd0, stat_addr(3), 8'h02);
    check("R6 one-cycle latency", int'(irq), 0);
    @(negedge clk);
    check("R6 line1 from blk3", int'(irq), 2'b10);
    rx_set[0] = 1;
    settle();
    bus_write(2'd0, 8'h0B, 8'hFF);
    bus_write(2'd0, 8'h00, 8'hFF);
    @(negedge clk); @(negedge clk);
    check("R5 other offset no mask", int'(irq), 2'b10);
    bus_write(2'd0, stat_addr(1), 8'hFF);
    @(negedge clk);
    check("R6 blk1 empty", int'(irq), 2'b10);
    tx_set[2] = 1;
    settle();
    @(negedge clk);
    check("R6 line0 from blk1", int'(irq), 2'b11);
    bus_write(2'd0, stat_addr(3), 8'h00);
    @(negedge clk);
    check("R5 mask clear drops line1", int'(irq), 2'b01);
    tx_clr[2] = 1; rx_clr[0] = 1; rx_clr[6] = 1;
    settle();
  endtask

  task automatic t_vector();
    logic [7:0] d;
    bus_write(2'd1, 8'd1, 8'hA5);
    bus_read(2'd2, 8'd0, d); check("R7 ack line0", int'(d), 8'hA5);
    bus_read(2'd2, 8'd2, d); check("R7 ack line1", int'(d), 8'hA5);
    bus_read(2'd2, 8'd1, d); check("R7 odd ack addr", int'(d), 0);
    bus_read(2'd2, 8'd4, d); check("R7 ack addr 4", int'(d), 0);
    bus_write(2'd3, 8'd1, 8'h3C);
    bus_read(2'd2, 8'd0, d); check("R8 mem space load", int'(d), 8'h3C);
    bus_write(2'd1, 8'd3, 8'h77);
    bus_write(2'd3, 8'd0, 8'h11);
    bus_read(2'd2, 8'd2, d); check("R8 other addr ignored", int'(d), 8'h3C);
  endtask

  task automatic t_readreg();
    logic [7:0] d;
    bus_read(2'd2, 8'd0, d);
    bus_write(2'd1, 8'd1, 8'h5A);
    @(negedge clk);
    check("R9 rdata held", int'(rdata), 8'h3C);
    bus_read(2'd1, 8'd1, d); check("R9 id read zero", int'(d), 0);
    bus_read(2'd2, 8'd0, d); check("R9 new vector", int'(d), 8'h5A);
    bus_read(2'd3, 8'd1, d); check("R9 mem read zero", int'(d), 0);
  endtask

  initial begin
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_setclr();
    t_break();
    t_mask_irq();
    t_vector();
    t_readreg();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule